// File: doc/BRIEF.md
# Lockable Two-Way Set-Associative Cache

This block is a 4-Kbyte instruction or data cache for a 32-bit processor port. It is built as two ways of 128 sets, and each line holds four 32-bit words. A request from the processor is looked up against both ways of the set that the address selects. A read that hits returns its word one cycle later. A read that misses loads the whole line from a word-wide memory port and then returns the requested word. Writes go through to memory. A write that hits also updates the cached copy. A write that misses leaves the cache unchanged.

Software can pin individual lines with a lock command. Replacement normally evicts the least recently used way of the set, but it never evicts a locked way. When both ways of a set are locked, a read miss is served by a single uncached memory read. An invalidate-all command empties the cache and releases every lock.

The processor port uses a request/ready handshake. A request is taken on a rising clock edge while `cpu_ready` is high, and its completion is signalled by a one-cycle `cpu_done` pulse. The memory port holds its request until the memory acknowledges it.

Top module: `dual_way_lock_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is high, `cpu_done` and `mem_req` are low, and the first read of any address misses.
- R2: The address is split as follows: bits [3:2] select the word, bits [10:4] select the set and bits [31:11] form the tag. Lines with different tags in one set are held apart, and each word of a line is returned from its own offset.
- R3: A read miss with a replaceable way performs exactly four memory reads, at line offsets 0, 4, 8 and 12 in that order. It then pulses `cpu_done` with `cpu_hit`=0 and the requested word on `cpu_rdata`.
- R4: A read hit makes no memory access and pulses `cpu_done` with `cpu_hit`=1 and the cached word at the first falling edge after acceptance.
- R5: Each set holds one replacement bit. A hit or a fill in a way makes the other way the next victim.
- R6: The lock command (`cpu_op`=2'b10) locks the matching line and reports `cpu_hit`=1. If exactly one way of the set is locked, a miss fills the unlocked way whatever the replacement bit says.
- R7: If both ways of the set are locked, a read miss makes exactly one memory read at the requested word address and returns that data. No line is filled, and the locked lines stay resident.
- R8: A write (`cpu_op`=2'b01) that hits updates the cached word and makes exactly one memory write with the same address and data.
- R9: A write that misses makes exactly one memory write and does not allocate a line, so a later read of that address misses.
- R10: Invalidate-all (`cpu_op`=2'b11) makes no memory access and clears every valid bit and every lock bit.
- R11: A lock command whose address is not resident reports `cpu_hit`=0 and has no effect, so that line can later be filled and evicted normally.
- R12: `cpu_ready` is low while any memory transfer is in progress. `mem_req` and `mem_addr` hold steady until `mem_ack`. Reads use `cpu_op`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_op | input | 2 | 00 read, 01 write, 10 lock line, 11 invalidate all |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Cache can take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request found its line resident (valid with `cpu_done`) |
| cpu_rdata | output | 32 | Read data (valid with `cpu_done` on reads) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current transfer |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
Lookups are exercised with three address patterns. Repeated words of one line show that word selection works. Three tags rotating through one set show whether the replacement bit follows hits as well as fills. A second set shows that sets are independent. Lock patterns cover every combination a set can reach. With no lock, the least recently used way is evicted. With one way locked, the lock overrides the replacement bit. With both ways locked, the miss is served by a single uncached read. A lock aimed at an absent line has no effect, which is seen when that line is later evicted as normal. Writes are tried both as hits and as misses, and the read that follows each write shows whether data was updated or a line was allocated.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_LOCK  = 2'b10,
    OP_INVAL = 2'b11
  } lkc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BYPASS,
    ST_WTHRU
  } lkc_state_e;
endpackage

// File: rtl/lkc_tag_store.sv
module lkc_tag_store #(
  parameter int SETS  = 128,
  parameter int TAG_W = 21,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [1:0]       hit_vec,
  output logic [1:0]       lock_vec,
  output logic             lru_way,
  output logic             any_valid,
  input  logic             fill_we,
  input  logic             fill_way,
  input  logic             lock_we,
  input  logic             lock_way,
  input  logic             lru_we,
  input  logic             lru_val,
  input  logic             inval_all
);
  logic [1:0]      vld_any;
  logic [SETS-1:0] lru_bits;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  vld;
    logic [SETS-1:0]  lck;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= '0;
        lck <= '0;
      end else if (inval_all) begin
        vld <= '0;
        lck <= '0;
      end else begin
        if (fill_we && fill_way == 1'(w)) vld[rd_set] <= 1'b1;
        if (lock_we && lock_way == 1'(w)) lck[rd_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_we && fill_way == 1'(w)) tags[rd_set] <= rd_tag;
    end

    assign hit_vec[w]  = vld[rd_set] && (tags[rd_set] == rd_tag);
    assign lock_vec[w] = lck[rd_set];
    assign vld_any[w]  = |vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_bits         <= '0;
    else if (lru_we) lru_bits[rd_set] <= lru_val;
  end

  assign lru_way   = lru_bits[rd_set];
  assign any_valid = |vld_any;
endmodule

// File: rtl/lkc_data_store.sv
module lkc_data_store #(
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int DEPTH = SETS * LINE_WORDS,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [1:0][DATA_W-1:0] rd_data,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == 1'(w)) mem[wr_idx] <= wr_data;
    end
    assign rd_data[w] = mem[rd_idx];
  end
endmodule

// File: rtl/lkc_victim_pick.sv
module lkc_victim_pick (
  input  logic       lru_way,
  input  logic [1:0] lock_vec,
  output logic       victim_way,
  output logic       no_way
);
  always_comb begin
    no_way = &lock_vec;
    unique case (lock_vec)
      2'b01:   victim_way = 1'b1;
      2'b10:   victim_way = 1'b0;
      default: victim_way = lru_way;
    endcase
  end
endmodule

// File: rtl/dual_way_lock_cache.sv
module dual_way_lock_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import lkc_pkg::*;

  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int WORD_W   = $clog2(LINE_WORDS);
  localparam int SET_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - SET_W - WORD_W - BYTE_OFF;
  localparam int IDX_W    = SET_W + WORD_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF+WORD_W +: SET_W];
  endfunction
  function automatic logic [WORD_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF +: WORD_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_word_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [WORD_W-1:0] w);
    return {a[ADDR_W-1:BYTE_OFF+WORD_W], w, {BYTE_OFF{1'b0}}};
  endfunction

  lkc_state_e        state;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              fill_way;
  logic [WORD_W-1:0] beat;
  logic              done_q, hit_q;
  logic [DATA_W-1:0] rdata_q;

  // lookup and event wires
  logic [ADDR_W-1:0]        lk_addr;
  logic [1:0]               hit_vec, lock_vec;
  logic                     lru_way, any_valid, lk_hit, hit_way;
  logic                     victim_way, no_way;
  logic [1:0][DATA_W-1:0]   rd_data;
  logic                     acc_go, rd_go, wr_go, lock_go, inval_go;
  logic                     fill_start, bypass_start, fill_beat_wr, fill_commit;
  logic                     unused_low;

  assign lk_addr  = (state == ST_IDLE) ? cpu_addr : req_addr;
  assign lk_hit   = |hit_vec;
  assign hit_way  = hit_vec[1];

  assign acc_go   = (state == ST_IDLE) && cpu_req;
  assign rd_go    = acc_go && (cpu_op == OP_READ);
  assign wr_go    = acc_go && (cpu_op == OP_WRITE);
  assign lock_go  = acc_go && (cpu_op == OP_LOCK);
  assign inval_go = acc_go && (cpu_op == OP_INVAL);
  assign fill_start   = rd_go && !lk_hit && !no_way;
  assign bypass_start = rd_go && !lk_hit && no_way;
  assign fill_beat_wr = (state == ST_FILL) && mem_ack;
  assign fill_commit  = fill_beat_wr && (beat == LAST_BEAT);
  assign unused_low   = ^req_addr[BYTE_OFF-1:0];

  lkc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (f_set(lk_addr)),
    .rd_tag    (f_tag(lk_addr)),
    .hit_vec   (hit_vec),
    .lock_vec  (lock_vec),
    .lru_way   (lru_way),
    .any_valid (any_valid),
    .fill_we   (fill_commit),
    .fill_way  (fill_way),
    .lock_we   (lock_go && lk_hit),
    .lock_way  (hit_way),
    .lru_we    (((rd_go || wr_go) && lk_hit) || fill_commit),
    .lru_val   (fill_commit ? ~fill_way : ~hit_way),
    .inval_all (inval_go)
  );

  lkc_victim_pick u_victim (
    .lru_way    (lru_way),
    .lock_vec   (lock_vec),
    .victim_way (victim_way),
    .no_way     (no_way)
  );

  lkc_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  (IDX_W'({f_set(lk_addr), f_word(lk_addr)})),
    .rd_data (rd_data),
    .wr_en   (fill_beat_wr || (wr_go && lk_hit)),
    .wr_way  (fill_beat_wr ? fill_way : hit_way),
    .wr_idx  (IDX_W'({f_set(lk_addr), fill_beat_wr ? beat : f_word(lk_addr)})),
    .wr_data (fill_beat_wr ? mem_rdata : cpu_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_addr  <= '0;
      req_wdata <= '0;
      fill_way  <= 1'b0;
      beat      <= '0;
      done_q    <= 1'b0;
      hit_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (cpu_req) begin
          req_addr  <= cpu_addr;
          req_wdata <= cpu_wdata;
          hit_q     <= lk_hit && (cpu_op != OP_INVAL);
          if (rd_go && lk_hit) begin
            done_q  <= 1'b1;
            rdata_q <= rd_data[hit_way];
          end else if (fill_start) begin
            state    <= ST_FILL;
            fill_way <= victim_way;
            beat     <= '0;
          end else if (bypass_start) begin
            state <= ST_BYPASS;
          end else if (wr_go) begin
            state <= ST_WTHRU;
          end else begin
            done_q <= 1'b1;
          end
        end
        ST_FILL: if (mem_ack) begin
          if (beat == f_word(req_addr)) rdata_q <= mem_rdata;
          beat <= beat + WORD_W'(1);
          if (beat == LAST_BEAT) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_BYPASS: if (mem_ack) begin
          rdata_q <= mem_rdata;
          state   <= ST_IDLE;
          done_q  <= 1'b1;
        end
        ST_WTHRU: if (mem_ack) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (state == ST_IDLE);
  assign cpu_done  = done_q;
  assign cpu_hit   = hit_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WTHRU);
  assign mem_addr  = f_word_addr(req_addr, (state == ST_FILL) ? beat : f_word(req_addr));
  assign mem_wdata = req_wdata;
endmodule

// File: rtl/lkc_checker.sv
module lkc_checker #(
  parameter int ADDR_W   = 32,
  parameter int BYTE_OFF = 2,
  parameter int WORD_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fill_start,
  input logic              bypass_start,
  input logic              wr_go,
  input logic              inval_go,
  input logic [1:0]        hit_vec,
  input logic [1:0]        lock_vec,
  input logic              victim_way,
  input logic              any_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready
);
  assert_hit_one_way_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_victim_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |-> !lock_vec[victim_way]);

  assert_fill_from_word0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> mem_req && !mem_we && (mem_addr[BYTE_OFF +: WORD_W] == '0));

  assert_bypass_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_start |=> mem_req && !mem_we &&
      (mem_addr[ADDR_W-1:BYTE_OFF] == $past(cpu_addr[ADDR_W-1:BYTE_OFF])));

  assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> mem_req && mem_we);

  assert_inval_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inval_go |=> !any_valid);

  assert_mem_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);
endmodule

bind dual_way_lock_cache lkc_checker #(
  .ADDR_W(ADDR_W), .BYTE_OFF(BYTE_OFF), .WORD_W(WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fill_start   (fill_start),
  .bypass_start (bypass_start),
  .wr_go        (wr_go),
  .inval_go     (inval_go),
  .hit_vec      (hit_vec),
  .lock_vec     (lock_vec),
  .victim_way   (victim_way),
  .any_valid    (any_valid),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .cpu_addr     (cpu_addr),
  .cpu_ready    (cpu_ready)
);

// File: tb/dual_way_lock_cache_bench.sv
module dual_way_lock_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [1:0]  cpu_op = 2'b00;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_done, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  dual_way_lock_cache u_dual_way_lock_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_checks = 0, n_errors = 0;
  int mem_reads = 0, mem_writes = 0;
  logic [31:0] rd_log [16];
  logic [31:0] last_waddr = '0, last_wdata = '0;

  // memory content: a fixed function of the word address; writes are only logged
  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h3C96_A5F0;
  endfunction

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem_f(mem_addr);
      if (mem_we) begin
        mem_writes <= mem_writes + 1;
        last_waddr <= mem_addr;
        last_wdata <= mem_wdata;
      end else begin
        rd_log[mem_reads % 16] <= mem_addr;
        mem_reads <= mem_reads + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // dsel: 0 no data check, 1 memory function of addr, 2 literal dlit
  task automatic expect_op(input string tag, input logic [1:0] op, input logic [31:0] addr,
                           input logic [31:0] wdata, input logic exp_hit, input int exp_rd,
                           input int exp_wr, input int dsel, input logic [31:0] dlit);
    int r0, w0, waits;
    logic ready_bad;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    r0 = mem_reads; w0 = mem_writes;
    cpu_req = 1'b1; cpu_op = op; cpu_addr = addr; cpu_wdata = wdata;
    @(negedge clk);
    cpu_req = 1'b0;
    waits = 0; ready_bad = 1'b0;
    while (!cpu_done && waits < 200) begin
      if (cpu_ready) ready_bad = 1'b1;
      waits++;
      @(negedge clk);
    end
    check({tag, " done"}, 32'(cpu_done), 32'd1);
    check({tag, " hit"}, 32'(cpu_hit), 32'(exp_hit));
    check({tag, " mem reads"}, 32'(mem_reads - r0), 32'(exp_rd));
    check({tag, " mem writes"}, 32'(mem_writes - w0), 32'(exp_wr));
    if (exp_rd + exp_wr > 0) check({tag, " R12 ready low while busy"}, 32'(ready_bad), 32'd0);
    else check({tag, " R4 one-cycle reply"}, 32'(waits), 32'd0);
    if (dsel == 1) check({tag, " data"}, cpu_rdata, mem_f(addr));
    if (dsel == 2) check({tag, " data"}, cpu_rdata, dlit);
    if (exp_rd == 4 && mem_reads - r0 == 4)
      for (int k = 0; k < 4; k++)
        check({tag, " R3 fill order"}, rd_log[(r0 + k) % 16], {addr[31:4], 4'h0} + 32'(4 * k));
    if (exp_rd == 1 && mem_reads - r0 == 1)
      check({tag, " R7 bypass addr"}, rd_log[r0 % 16], {addr[31:2], 2'b00});
    if (exp_wr == 1 && mem_writes - w0 == 1) begin
      check({tag, " write addr"}, last_waddr, {addr[31:2], 2'b00});
      check({tag, " write data"}, last_wdata, wdata);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        hit;
    logic [2:0]  nrd;
    logic        nwr;
    logic [1:0]  dsel;
    logic [31:0] dlit;
  } vec_t;

  // set 5 tags 1,2,3 at 0x850/0x1050/0x1850; set 6 at 0x60
  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{2'b00, 32'h0000_0854, 32'h0, 1'b0, 3'd4, 1'b0, 2'd1, 32'h0},          // R3 miss fill
    '{2'b00, 32'h0000_0858, 32'h0, 1'b1, 3'd0, 1'b0, 2'd1, 32'h0},          // R4 hit
    '{2'b00, 32'h0000_1050, 32'h0, 1'b0, 3'd4, 1'b0, 2'd1, 32'h0},          // R2 same set, other tag
    '{2'b00, 32'h0000_085C, 32'h0, 1'b1, 3'd0, 1'b0, 2'd1, 32'h0},          // R5 touch A
    '{2'b00, 32'h0000_1850, 32'h0, 1'b0, 3'd4, 1'b0, 2'd1, 32'h0},          // R5 evicts B
    '{2'b00, 32'h0000_0850, 32'h0, 1'b1, 3'd0, 1'b0, 2'd1, 32'h0},          // R5 A kept
    '{2'b00, 32'h0000_1050, 32'h0, 1'b0, 3'd4, 1'b0, 2'd1, 32'h0},          // R5 B gone
    '{2'b01, 32'h0000_0854, 32'hDEAD_BEEF, 1'b1, 3'd0, 1'b1, 2'd0, 32'h0},  // R8 write hit
    '{2'b00, 32'h0000_0854, 32'h0, 1'b1, 3'd0, 1'b0, 2'd2, 32'hDEAD_BEEF},  // R8 updated word
    '{2'b01, 32'h0000_2854, 32'h1234_5678, 1'b0, 3'd0, 1'b1, 2'd0, 32'h0},  // R9 write miss
    '{2'b00, 32'h0000_2854, 32'h0, 1'b0, 3'd4, 1'b0, 2'd1, 32'h0},          // R9 not allocated
    '{2'b00, 32'h0000_0060, 32'h0, 1'b0, 3'd4, 1'b0, 2'd1, 32'h0},          // R2 other set
    '{2'b00, 32'h0000_006C, 32'h0, 1'b1, 3'd0, 1'b0, 2'd1, 32'h0}           // R2 word 3
  };

  function automatic string row_tag(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2, 11, 12: return "R2";
      7, 8: return "R8";
      9, 10: return "R9";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(cpu_ready), 32'd1);
    check("R1 done low after reset", 32'(cpu_done), 32'd0);
    check("R1 mem idle after reset", 32'(mem_req), 32'd0);

    for (int i = 0; i < NVEC; i++)
      expect_op($sformatf("%s row%0d", row_tag(i), i), VEC[i].op, VEC[i].addr, VEC[i].wdata,
                VEC[i].hit, int'(VEC[i].nrd), int'(VEC[i].nwr), int'(VEC[i].dsel), VEC[i].dlit);

    // R6: set 9, D=0x890 E=0x1090 F=0x1890
    expect_op("R6 fill D", 2'b00, 32'h0890, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R6 fill E", 2'b00, 32'h1090, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R6 lock D", 2'b10, 32'h0890, 0, 1'b1, 0, 0, 0, 0);
    expect_op("R6 F skips locked LRU", 2'b00, 32'h1890, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R6 D kept", 2'b00, 32'h0894, 0, 1'b1, 0, 0, 1, 0);
    expect_op("R6 E evicted", 2'b00, 32'h1090, 0, 1'b0, 4, 0, 1, 0);
    // R7: both ways locked
    expect_op("R7 lock E", 2'b10, 32'h1090, 0, 1'b1, 0, 0, 0, 0);
    expect_op("R7 bypass read", 2'b00, 32'h1898, 0, 1'b0, 1, 0, 1, 0);
    expect_op("R7 no fill", 2'b00, 32'h1898, 0, 1'b0, 1, 0, 1, 0);
    expect_op("R7 D resident", 2'b00, 32'h0890, 0, 1'b1, 0, 0, 1, 0);
    expect_op("R7 E resident", 2'b00, 32'h109C, 0, 1'b1, 0, 0, 1, 0);
    // R11: lock of an absent line, set 12
    expect_op("R11 lock absent", 2'b10, 32'h08C0, 0, 1'b0, 0, 0, 0, 0);
    expect_op("R11 fill X", 2'b00, 32'h08C0, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R11 fill Y", 2'b00, 32'h10C0, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R11 fill Z", 2'b00, 32'h18C0, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R11 X evicted", 2'b00, 32'h08C0, 0, 1'b0, 4, 0, 1, 0);
    // R10: invalidate all
    expect_op("R10 invalidate", 2'b11, 32'h0, 0, 1'b0, 0, 0, 0, 0);
    expect_op("R10 D misses", 2'b00, 32'h0890, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R10 E misses", 2'b00, 32'h1090, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R10 locks gone", 2'b00, 32'h1890, 0, 1'b0, 4, 0, 1, 0);
    expect_op("R10 F hit", 2'b00, 32'h1890, 0, 1'b1, 0, 0, 1, 0);
    expect_op("R1 table line gone", 2'b00, 32'h0060, 0, 1'b0, 4, 0, 1, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule